// File: doc/BRIEF.md
# Flash Write-Completion Poller

This block sits on the host side of a parallel NOR flash. Once software or a sequencer has finished writing a program or erase command to the device, it pulses `start_i` along with the byte it expected to write and a flag that marks an erase. The poller then reads the target location over and over through a simple request/response port, and decides when the internal write has finished. It can detect completion in either of two ways, chosen per operation:

- **Polarity mode** watches the polarity status bit.
- **Toggle mode** watches whether the toggle status bit alternates between consecutive reads.

The device finishes its write asynchronously to the host, so a read that lands on the completion instant can return a mix of old and new data. To guard against this, the poller does not accept an apparent completion at once. It reads the location two more times, and both reads must still show completion. The last of these full reads is then compared with the intended contents. Any failed confirmation sends the poller back to ordinary polling. A per-operation limit on the number of reads turns a device that never finishes into a timeout.

The poller does not generate bus timing. It also does not enforce when polling may begin: the host must raise `start_i` only after the last command write has been issued, which is the fourth write for a program and the sixth write for an erase.

Top module: `flash_done_poller`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `pass_o`, `timeout_o` and `rd_req_o` are all 0.
- R2: `start_i` while idle makes `busy_o` high on the next cycle. The first read request follows. `rd_req_o` is a one-cycle pulse, and there is never more than one read outstanding: the next request comes only after `rd_valid_i` has returned the previous one.
- R3: In polarity mode for a program, a read counts as complete when bit 7 of the read data equals bit 7 of `exp_data_i`.
- R4: In polarity mode for an erase, a read counts as complete when bit 7 is 1. A read with bit 7 at 0 means the erase is still running.
- R5: In toggle mode, a read counts as complete only when bit 6 equals bit 6 of the immediately preceding read of the same operation. The first read of an operation never counts as complete.
- R6: After a first complete read, exactly two further reads are taken. Both must also count as complete for the operation to finish. If either does not, polling resumes, and a later complete read starts a new confirmation.
- R7: When the second confirming read arrives, `pass_o` is 1 exactly when that full read equals `exp_data_i`, or 8'hFF for an erase.
- R8: If the number of returned reads reaches the `poll_limit_i` value latched at start without a decision, the operation ends with `timeout_o`=1 and `pass_o`=0. A decision made on the read that reaches the limit wins over the timeout.
- R9: `done_o` is a single-cycle pulse at the end of each operation. `pass_o` and `timeout_o` are never both 1, and they hold their values until the next accepted start.
- R10: `start_i` while `busy_o` is high is ignored. The running operation finishes with its own mode, flag, expected data and limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin polling; accepted only when idle |
| erase_i | input | 1 | Operation is an erase (target value all ones) |
| toggle_mode_i | input | 1 | 1: toggle-bit detection, 0: polarity-bit detection |
| exp_data_i | input | DATA_W | Byte that was programmed |
| poll_limit_i | input | CNT_W | Maximum number of reads for this operation |
| rd_req_o | output | 1 | Read request pulse towards the flash |
| rd_valid_i | input | 1 | Read data returned |
| rd_data_i | input | DATA_W | Data of the returned read |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle end-of-operation pulse |
| pass_o | output | 1 | Operation completed with correct data |
| timeout_o | output | 1 | Operation ended at the read limit |

## Verification
The assertions watch the handshake and outcome shape on every cycle:

- single-cycle request pulses;
- busy rising after an accepted start;
- a one-cycle done pulse;
- pass and timeout that are mutually exclusive and held while idle;
- operation parameters that stay frozen when a start arrives during a poll.

Whether a given read sequence counts as complete in each mode, how a failed confirmation falls back to polling, and how the final data comparison and the read limit interact can only be shown by the bench's scripted read sequences. The bench checks these through the number of reads consumed and the final flags.

// File: rtl/flash_poll_pkg.sv
package flash_poll_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } poll_state_e;
endpackage

// File: rtl/poll_status_eval.sv
module poll_status_eval #(
  parameter int DATA_W   = 8,
  parameter int POLL_BIT = 7,
  parameter int TOG_BIT  = 6
) (
  input  logic [DATA_W-1:0] rd_data_i,
  input  logic [DATA_W-1:0] exp_data_i,
  input  logic              erase_i,
  input  logic              toggle_mode_i,
  input  logic              prev_tog_i,
  input  logic              prev_vld_i,
  output logic              complete_o,
  output logic              final_ok_o
);
  logic [DATA_W-1:0] target;
  logic              pol_done;
  logic              tog_done;

  assign target   = erase_i ? {DATA_W{1'b1}} : exp_data_i;
  // erase reports 0 while busy, program reports inverted bit while busy
  assign pol_done = erase_i ? rd_data_i[POLL_BIT]
                            : (rd_data_i[POLL_BIT] == exp_data_i[POLL_BIT]);
  assign tog_done = prev_vld_i && (rd_data_i[TOG_BIT] == prev_tog_i);

  assign complete_o = toggle_mode_i ? tog_done : pol_done;
  assign final_ok_o = (rd_data_i == target);
endmodule

// File: rtl/poll_read_counter.sv
module poll_read_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic [CNT_W-1:0] limit_i,
  input  logic             inc_i,
  output logic             hit_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] limit_q;
  logic [CNT_W:0]   cnt_next;

  assign cnt_next = {1'b0, cnt_q} + {{CNT_W{1'b0}}, 1'b1};
  // this increment reaches the limit
  assign hit_o    = cnt_next >= {1'b0, limit_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      limit_q <= '0;
    end else if (clr_i) begin
      cnt_q   <= '0;
      limit_q <= limit_i;
    end else if (inc_i && (cnt_q != {CNT_W{1'b1}})) begin
      cnt_q <= cnt_next[CNT_W-1:0];
    end
  end

  assert_limit_frozen_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> $stable(limit_q));
endmodule

// File: rtl/poll_confirm_track.sv
module poll_confirm_track #(
  parameter int CONFIRM_READS = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic sample_i,
  input  logic complete_i,
  output logic confirming_o,
  output logic last_o
);
  localparam int NW = $clog2(CONFIRM_READS + 1);
  localparam logic [NW-1:0] LAST = NW'(CONFIRM_READS - 1);

  logic          active_q;
  logic [NW-1:0] n_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      n_q      <= '0;
    end else if (clr_i) begin
      active_q <= 1'b0;
      n_q      <= '0;
    end else if (sample_i) begin
      if (!active_q) begin
        active_q <= complete_i;
        n_q      <= '0;
      end else if (!complete_i) begin
        active_q <= 1'b0;  // apparent result rejected, back to polling
        n_q      <= '0;
      end else if (n_q != LAST) begin
        n_q <= n_q + 1'b1;
      end
    end
  end

  assign confirming_o = active_q;
  assign last_o       = active_q && (n_q == LAST);

  assert_confirm_drop_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_i && active_q && !complete_i && !clr_i) |=> !active_q);
endmodule

// File: rtl/flash_done_poller.sv
module flash_done_poller
  import flash_poll_pkg::*;
#(
  parameter int DATA_W        = 8,
  parameter int CNT_W         = 8,
  parameter int POLL_BIT      = 7,
  parameter int TOG_BIT       = 6,
  parameter int CONFIRM_READS = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              erase_i,
  input  logic              toggle_mode_i,
  input  logic [DATA_W-1:0] exp_data_i,
  input  logic [CNT_W-1:0]  poll_limit_i,
  output logic              rd_req_o,
  input  logic              rd_valid_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              pass_o,
  output logic              timeout_o
);
  poll_state_e       state_q;
  logic [DATA_W-1:0] exp_q;
  logic              erase_q;
  logic              tog_mode_q;
  logic              prev_tog_q;
  logic              prev_vld_q;
  logic              done_q;
  logic              pass_q;
  logic              to_q;

  logic accept;
  logic resp;
  logic complete;
  logic final_ok;
  logic hit;
  logic confirming;
  logic last;
  logic decide;
  logic give_up;

  assign accept = (state_q == ST_IDLE) && start_i;
  assign resp   = (state_q == ST_WAIT) && rd_valid_i;

  poll_status_eval #(
    .DATA_W  (DATA_W),
    .POLL_BIT(POLL_BIT),
    .TOG_BIT (TOG_BIT)
  ) u_eval (
    .rd_data_i    (rd_data_i),
    .exp_data_i   (exp_q),
    .erase_i      (erase_q),
    .toggle_mode_i(tog_mode_q),
    .prev_tog_i   (prev_tog_q),
    .prev_vld_i   (prev_vld_q),
    .complete_o   (complete),
    .final_ok_o   (final_ok)
  );

  poll_read_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (accept),
    .limit_i(poll_limit_i),
    .inc_i  (resp),
    .hit_o  (hit)
  );

  poll_confirm_track #(.CONFIRM_READS(CONFIRM_READS)) u_conf (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (accept),
    .sample_i    (resp),
    .complete_i  (complete),
    .confirming_o(confirming),
    .last_o      (last)
  );

  assign decide  = resp && confirming && last && complete;
  assign give_up = resp && !decide && hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      exp_q      <= '0;
      erase_q    <= 1'b0;
      tog_mode_q <= 1'b0;
      prev_tog_q <= 1'b0;
      prev_vld_q <= 1'b0;
      done_q     <= 1'b0;
      pass_q     <= 1'b0;
      to_q       <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            exp_q      <= exp_data_i;
            erase_q    <= erase_i;
            tog_mode_q <= toggle_mode_i;
            prev_vld_q <= 1'b0;
            pass_q     <= 1'b0;
            to_q       <= 1'b0;
            state_q    <= ST_ISSUE;
          end
        end
        ST_ISSUE: state_q <= ST_WAIT;
        ST_WAIT: begin
          if (rd_valid_i) begin
            prev_tog_q <= rd_data_i[TOG_BIT];
            prev_vld_q <= 1'b1;
            if (decide) begin
              done_q  <= 1'b1;
              pass_q  <= final_ok;
              state_q <= ST_IDLE;
            end else if (give_up) begin
              done_q  <= 1'b1;
              to_q    <= 1'b1;
              state_q <= ST_IDLE;
            end else begin
              state_q <= ST_ISSUE;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign rd_req_o  = (state_q == ST_ISSUE);
  assign busy_o    = (state_q != ST_IDLE);
  assign done_o    = done_q;
  assign pass_o    = pass_q;
  assign timeout_o = to_q;

  assert_req_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o |=> !rd_req_o);
  assert_busy_on_start_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o);
  assert_done_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_pass_to_excl_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pass_o && timeout_o));
  assert_outcome_held_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> ($stable(pass_o) && $stable(timeout_o)));
  assert_start_ignored_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> ($stable(exp_q) && $stable(erase_q) && $stable(tog_mode_q)));
endmodule

// File: tb/flash_done_poller_bench.sv
module flash_done_poller_bench;
  localparam int NV = 10;

  // {toggle, erase, exp[7:0], limit[7:0], script[63:0] (byte0 lowest), reads[7:0], pass, timeout}
  localparam logic [91:0] VEC [NV] = '{
    {1'b0, 1'b0, 8'h5A, 8'd16, 64'h5A5A5A5A_5A5A8080, 8'd5, 1'b1, 1'b0},
    {1'b0, 1'b1, 8'h00, 8'd16, 64'hFFFFFFFF_FFFF0000, 8'd5, 1'b1, 1'b0},
    {1'b0, 1'b0, 8'h5A, 8'd16, 64'h5A5A5A5A_5A800080, 8'd6, 1'b1, 1'b0},
    {1'b1, 1'b0, 8'h3C, 8'd16, 64'h3C3C3C3C_3C400040, 8'd7, 1'b1, 1'b0},
    {1'b0, 1'b0, 8'h5A, 8'd16, 64'h5B5B5B5B_5B5B5B5B, 8'd3, 1'b0, 1'b0},
    {1'b0, 1'b0, 8'h00, 8'd4,  64'h80808080_80808080, 8'd4, 1'b0, 1'b1},
    {1'b1, 1'b1, 8'h00, 8'd16, 64'hFFFFFFFF_FFFF0040, 8'd6, 1'b1, 1'b0},
    {1'b0, 1'b1, 8'h00, 8'd16, 64'h80808080_80808080, 8'd3, 1'b0, 1'b0},
    {1'b0, 1'b0, 8'h00, 8'd2,  64'h00000000_00000000, 8'd2, 1'b0, 1'b1},
    {1'b0, 1'b0, 8'h00, 8'd3,  64'h00000000_00000000, 8'd3, 1'b1, 1'b0}
  };

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0;
  logic       erase_i = 1'b0;
  logic       toggle_mode_i = 1'b0;
  logic [7:0] exp_data_i = '0;
  logic [7:0] poll_limit_i = '0;
  logic       rd_req_o;
  logic       rd_valid_i = 1'b0;
  logic [7:0] rd_data_i = '0;
  logic       busy_o, done_o, pass_o, timeout_o;

  int checks = 0;
  int errors = 0;
  int nreq = 0;
  int cycles = 0;
  logic [63:0] script = '0;
  logic saw_done;

  always #5 clk_i = ~clk_i;

  flash_done_poller u_flash_done_poller (
    .clk_i, .rst_ni, .start_i, .erase_i, .toggle_mode_i, .exp_data_i,
    .poll_limit_i, .rd_req_o, .rd_valid_i, .rd_data_i,
    .busy_o, .done_o, .pass_o, .timeout_o
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic string tag_of(input int i);
    case (i)
      0: return "R3";
      1: return "R4";
      2: return "R6";
      3: return "R5";
      4: return "R7";
      5: return "R8";
      6: return "R5";
      7: return "R7";
      8: return "R8";
      default: return "R6";
    endcase
  endfunction

  // flash model: one-cycle gap, then data; R2 single pulse checked
  initial begin
    forever begin
      @(negedge clk_i);
      rd_valid_i = 1'b0;
      if (rd_req_o) begin
        nreq++;
        @(negedge clk_i);
        check(!rd_req_o, "R2 request pulse", int'(rd_req_o), 0);
        rd_valid_i = 1'b1;
        rd_data_i  = script[8*((nreq > 8 ? 8 : nreq) - 1) +: 8];
      end
    end
  end

  initial begin
    forever begin
      @(posedge clk_i);
      cycles++;
      if (cycles == 100000) begin
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  task automatic run_case(input logic tog, input logic er, input logic [7:0] exp,
                          input logic [7:0] lim, input logic [63:0] scr, input bit inject);
    script        = scr;
    nreq          = 0;
    saw_done      = 1'b0;
    @(negedge clk_i);
    toggle_mode_i = tog;
    erase_i       = er;
    exp_data_i    = exp;
    poll_limit_i  = lim;
    start_i       = 1'b1;
    @(negedge clk_i);
    start_i       = 1'b0;
    check(busy_o, "R2 busy after start", int'(busy_o), 1);
    for (int k = 0; k < 200; k++) begin
      @(negedge clk_i);
      if (inject && k == 2) begin
        start_i = 1'b1; erase_i = 1'b1; toggle_mode_i = 1'b1;
        exp_data_i = 8'h80; poll_limit_i = 8'd1;
      end else begin
        start_i = 1'b0;
      end
      if (done_o) begin
        saw_done = 1'b1;
        break;
      end
    end
    start_i = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    check(!busy_o && !done_o && !pass_o && !timeout_o && !rd_req_o, "R1 reset outputs",
          int'({busy_o, done_o, pass_o, timeout_o, rd_req_o}), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(!busy_o && !rd_req_o, "R1 idle after reset", int'({busy_o, rd_req_o}), 0);

    for (int i = 0; i < NV; i++) begin
      run_case(VEC[i][91], VEC[i][90], VEC[i][89:82], VEC[i][81:74], VEC[i][73:10], 1'b0);
      check(saw_done, $sformatf("%s vec%0d done", tag_of(i), i), int'(saw_done), 1);
      check(nreq == int'(VEC[i][9:2]), $sformatf("%s vec%0d reads", tag_of(i), i),
            nreq, int'(VEC[i][9:2]));
      check(pass_o == VEC[i][1], $sformatf("R7 vec%0d pass", i), int'(pass_o), int'(VEC[i][1]));
      check(timeout_o == VEC[i][0], $sformatf("R8 vec%0d timeout", i),
            int'(timeout_o), int'(VEC[i][0]));
      repeat (2) @(negedge clk_i);
    end

    // R9: done is a pulse, outcome held while idle
    run_case(1'b0, 1'b0, 8'h5A, 8'd16, 64'h5A5A5A5A_5A5A8080, 1'b0);
    @(negedge clk_i);
    check(!done_o, "R9 done single cycle", int'(done_o), 0);
    repeat (4) @(negedge clk_i);
    check(pass_o && !timeout_o && !busy_o, "R9 outcome held",
          int'({pass_o, timeout_o, busy_o}), 4);

    // R10: start during a poll with other settings has no effect
    run_case(1'b0, 1'b0, 8'h5A, 8'd16, 64'h5A5A5A5A_5A5A8080, 1'b1);
    check(nreq == 5, "R10 reads unchanged", nreq, 5);
    check(pass_o && !timeout_o, "R10 outcome unchanged", int'({pass_o, timeout_o}), 2);
    repeat (3) @(negedge clk_i);
    check(!busy_o && nreq == 5, "R10 no restart", int'(busy_o), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule